// File: doc/BRIEF.md
# Edge-Driven Event Counter with Compare Clear

This block counts transitions on an asynchronous external event line and signals every time a programmed number of transitions has gone by. The line is brought into the system clock domain through a synchronizer chain, and a selectable edge (rising, falling, both or none) is turned into a one-cycle count strobe. A 16-bit counter advances on each strobe. When the counter reaches the compare value, the next strobe returns it to zero, so the count runs from zero up to the compare value and starts again.

Software sets the block up through a plain write port: an enable register, a mode field, an edge-select field and a compare register. The compare value is not used directly. It is copied into a shadow buffer at the moment counting is switched on. While stopped, the counter rests at all-ones, so the first counted edge takes it to zero. A single-cycle interrupt pulse marks the edge on which the count reaches the buffered compare value. This gives one pulse for every compare-plus-one valid edges.

Top module: `evc_top`

## Requirements
- R1: After reset, count_o reads 16'hFFFF, irq_o is 0 and counting is disabled.
- R2: A write with wr_en high lands at the rising clock edge. Address 0 bit 0 is the enable bit. Address 1 bits 2:0 hold the mode, and 3'b001 selects event counting. Address 2 bits 1:0 hold the edge select. Address 3 holds the 16-bit compare value.
- R3: Edge-select encoding: 2'b00 counts no edge, 2'b01 counts rising edges, 2'b10 counts falling edges and 2'b11 counts both. An edge that is not selected leaves count_o unchanged.
- R4: A transition on ev_in that is set up before a rising clock edge is counted at the third rising clock edge from that one, and any interrupt it causes is high during the following cycle.
- R5: While enabled in event mode, the first valid edge moves the count from 16'hFFFF to 0, and each later valid edge adds one.
- R6: When the count equals the buffered compare value, the next valid edge sets it to 0.
- R7: irq_o is high for exactly one clock cycle after each valid edge that makes the count equal to the buffered compare value N. This happens at valid edges N+1, 2(N+1), 3(N+1) and so on.
- R8: The compare buffer loads from the compare register only when the enable bit is written from 0 to 1. Compare writes made while running do not change the interrupt period until counting is disabled and enabled again.
- R9: A write that clears the enable bit sets the count to 16'hFFFF at that clock edge and blocks any interrupt, including one from a valid edge that falls at the same edge.
- R10: While enabled with a mode value other than 3'b001, valid edges do not change the count and raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| ev_in | input | 1 | Asynchronous external event line |
| irq_o | output | 1 | Compare-match interrupt pulse |
| count_o | output | 16 | Current counter value |

## Verification
The whole state of the block can be seen on count_o and irq_o. A counter that steps or clears wrongly shows a wrong count_o three clocks after the transition on ev_in that caused it. A stale or reloaded compare buffer shows up as an interrupt at the wrong edge within one period. An edge-select fault shows up as a count that moves on an edge that should be ignored, or that stays put on one that should count. A disable path that leaks shows up at once: the count is not all-ones, or a stray pulse appears, in the cycle after the disabling write.

// File: rtl/evc_pkg.sv
package evc_pkg;
    localparam int unsigned REG_AW = 2;

    localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] A_MODE = 2'd1;
    localparam logic [REG_AW-1:0] A_EDGE = 2'd2;
    localparam logic [REG_AW-1:0] A_CMP  = 2'd3;

    localparam int unsigned MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_EVENT = 3'b001;

    typedef enum logic [1:0] {
        ESEL_NONE = 2'b00,
        ESEL_RISE = 2'b01,
        ESEL_FALL = 2'b10,
        ESEL_BOTH = 2'b11
    } esel_e;
endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.chain[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/evc_edge.sv
module evc_edge
    import evc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lvl_i,
    input  esel_e esel_i,
    output logic  hit_o
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic rise, fall;

    always_comb begin
        st_d.prev = lvl_i;
        rise      = lvl_i & ~st_q.prev;
        fall      = ~lvl_i & st_q.prev;
        unique case (esel_i)
            ESEL_RISE: hit_o = rise;
            ESEL_FALL: hit_o = fall;
            ESEL_BOTH: hit_o = rise | fall;
            default:   hit_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/evc_regs.sv
module evc_regs
    import evc_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] wr_addr_i,
    input  logic [DW-1:0]     wr_data_i,
    output logic              en_o,
    output logic              stop_o,
    output logic              load_o,
    output logic [MODE_W-1:0] mode_o,
    output esel_e             esel_o,
    output logic [DW-1:0]     cmp_o
);
    typedef struct packed {
        logic              en;
        logic [MODE_W-1:0] mode;
        esel_e             esel;
        logic [DW-1:0]     cmp;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    ctrl_wr;

    always_comb begin
        st_d    = st_q;
        ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);
        if (wr_en_i) begin
            unique case (wr_addr_i)
                A_CTRL: st_d.en   = wr_data_i[0];
                A_MODE: st_d.mode = wr_data_i[MODE_W-1:0];
                A_EDGE: st_d.esel = esel_e'(wr_data_i[1:0]);
                default: st_d.cmp = wr_data_i;
            endcase
        end
        load_o = ctrl_wr && wr_data_i[0] && !st_q.en;
        stop_o = ctrl_wr && !wr_data_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{en: 1'b0, mode: '0, esel: ESEL_NONE, cmp: '0};
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign mode_o = st_q.mode;
    assign esel_o = st_q.esel;
    assign cmp_o  = st_q.cmp;

    // R8
    load_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> en_o);

    // R2
    cmp_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == A_CMP) |=> (cmp_o == $past(wr_data_i)));
endmodule

// File: rtl/evc_core.sv
module evc_core #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         stop_i,
    input  logic         load_i,
    input  logic         run_i,
    input  logic         hit_i,
    input  logic [W-1:0] cmp_i,
    output logic [W-1:0] cnt_o,
    output logic         irq_o
);
    localparam logic [W-1:0] PARK = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cbuf;
        logic         irq;
    } core_st_t;

    core_st_t     st_d, st_q;
    logic [W-1:0] nxt;
    logic         step;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        step     = en_i && !stop_i && run_i && hit_i;
        nxt      = (st_q.cnt == st_q.cbuf) ? '0 : st_q.cnt + 1'b1;
        if (load_i) st_d.cbuf = cmp_i;
        if (!en_i || stop_i) begin
            st_d.cnt = PARK;
        end else if (step) begin
            st_d.cnt = nxt;
            st_d.irq = (nxt == st_q.cbuf);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: PARK, cbuf: '0, irq: 1'b0};
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign irq_o = st_q.irq;

    // R9
    park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || stop_i) |=> (cnt_o == PARK && !irq_o));

    // R7
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cnt_o == st_q.cbuf));

    // R8
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(st_q.cbuf));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !stop_i && run_i && hit_i && st_q.cnt != st_q.cbuf)
            |=> (cnt_o == W'($past(st_q.cnt) + 1'b1)));

    // R6
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !stop_i && run_i && hit_i && st_q.cnt == st_q.cbuf)
            |=> (cnt_o == '0));

    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !stop_i && !(run_i && hit_i)) |=> ($stable(cnt_o) && !irq_o));
endmodule

// File: rtl/evc_top.sv
module evc_top
    import evc_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              ev_in,
    output logic              irq_o,
    output logic [CNT_W-1:0]  count_o
);
    logic              ev_sync;
    logic              hit;
    logic              en, stop, load, run;
    logic [MODE_W-1:0] mode;
    esel_e             esel;
    logic [CNT_W-1:0]  cmp;

    evc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ev_in), .q_o(ev_sync)
    );

    evc_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(ev_sync), .esel_i(esel), .hit_o(hit)
    );

    evc_regs #(.DW(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .en_o(en), .stop_o(stop), .load_o(load),
        .mode_o(mode), .esel_o(esel), .cmp_o(cmp)
    );

    assign run = (mode == MODE_EVENT);

    evc_core #(.W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .en_i(en), .stop_i(stop), .load_i(load), .run_i(run),
        .hit_i(hit), .cmp_i(cmp),
        .cnt_o(count_o), .irq_o(irq_o)
    );
endmodule

// File: tb/evc_top_test.sv
module evc_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ev_in = 1'b0;
    logic        irq_o;
    logic [15:0] count_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    evc_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ev_in(ev_in), .irq_o(irq_o), .count_o(count_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // flip ev_in, then watch five cycles for the interrupt pulse
    task automatic step(output int hits, output int cyc);
        hits = 0; cyc = 0;
        @(negedge clk);
        ev_in = ~ev_in;
        for (int c = 1; c <= 5; c++) begin
            @(negedge clk);
            if (irq_o) begin hits++; cyc = c; end
        end
    endtask

    function automatic bit is_valid(input int es, input logic lvl);
        return (es == 3) || (es == 1 && lvl) || (es == 2 && !lvl);
    endfunction

    task automatic start(input int n, input int es, input int mode);
        wr(2'd0, 16'd0);
        wr(2'd3, 16'(n));
        wr(2'd2, 16'(es));
        wr(2'd1, 16'(mode));
        wr(2'd0, 16'd1);
    endtask

    initial begin
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int nlist[4];
        int hits, cyc, expc, k;
        bit v, expirq;
        logic nl;
        nlist = '{0, 1, 2, 5};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(count_o == 16'hFFFF, "R1 reset count", count_o, 65535);
        chk(irq_o == 1'b0, "R1 reset irq", irq_o, 0);
        step(hits, cyc);
        chk(hits == 0 && count_o == 16'hFFFF, "R1 disabled after reset", count_o, 65535);

        // sweep of compare values and edge modes: R2 R3 R4 R5 R6 R7
        for (int ni = 0; ni < 4; ni++) begin
            for (int es = 1; es <= 3; es++) begin
                start(nlist[ni], es, 1);
                chk(count_o == 16'hFFFF, "R5 parked at start", count_o, 65535);
                k = 0;
                for (int t = 0; t < 4 * (nlist[ni] + 1) + 2; t++) begin
                    nl = ~ev_in;
                    v = is_valid(es, nl);
                    step(hits, cyc);
                    if (v) k++;
                    expc = (k == 0) ? 65535 : (k - 1) % (nlist[ni] + 1);
                    expirq = v && (k % (nlist[ni] + 1) == 0);
                    chk(hits == int'(expirq), "R7 irq pulses per edge", hits, int'(expirq));
                    if (expirq) chk(cyc == 3, "R4 irq latency", cyc, 3);
                    if (v && k > 1 && expc == 0)
                        chk(count_o == 16'(expc), "R6 clear after match", count_o, expc);
                    else if (v)
                        chk(count_o == 16'(expc), "R5 count step", count_o, expc);
                    else
                        chk(count_o == 16'(expc), "R3 unselected edge ignored", count_o, expc);
                end
            end
        end

        // R3 edge select none
        start(0, 0, 1);
        for (int t = 0; t < 4; t++) begin
            step(hits, cyc);
            chk(hits == 0 && count_o == 16'hFFFF, "R3 select none", count_o, 65535);
        end

        // R10 other mode holds
        start(0, 3, 2);
        for (int t = 0; t < 4; t++) begin
            step(hits, cyc);
            chk(hits == 0 && count_o == 16'hFFFF, "R10 wrong mode holds", count_o, 65535);
        end

        // R8 compare write while running is ignored
        start(2, 3, 1);
        k = 0;
        for (int t = 1; t <= 6; t++) begin
            if (t == 4) wr(2'd3, 16'd5);
            step(hits, cyc);
            chk(hits == int'(t % 3 == 0), "R8 period kept after compare write", hits, int'(t % 3 == 0));
        end
        wr(2'd0, 16'd0);
        wr(2'd0, 16'd1);
        for (int t = 1; t <= 6; t++) begin
            step(hits, cyc);
            chk(hits == int'(t == 6), "R8 new period after re-enable", hits, int'(t == 6));
        end
        chk(count_o == 16'd5, "R8 count at new compare", count_o, 5);

        // R9 disable at the same edge as a valid transition
        start(0, 3, 1);
        @(negedge clk);
        ev_in = ~ev_in;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'd0;
        @(negedge clk);
        wr_en = 1'b0;
        chk(irq_o == 1'b0, "R9 irq blocked on disable", irq_o, 0);
        chk(count_o == 16'hFFFF, "R9 count parked on disable", count_o, 65535);
        @(negedge clk);
        chk(irq_o == 1'b0, "R9 no late irq", irq_o, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule